// File: doc/BRIEF.md
# Bit-Serial Mode-Switched Register Interface

This block sits between a CPU's bit-addressed serial register bus and a small peripheral core that holds interrupt lines, a countdown timer and sixteen general-purpose pins. Every bus location is one bit wide. A 5-bit select address picks the location. A write strobe stores a single data bit there. A read returns one bit, and it returns it in the same cycle.

A mode bit at location 0 decides how locations 1 to 15 are used. In interrupt mode those locations are interrupt enable bits, and reading them returns the interrupt line levels. In clock mode they become the timer interval bits, the latched count, the request level and a soft-reset control. Locations 16 to 31 are the parallel pins. Writing one of them drives the pin and turns it into an output. Any access to that upper half drops the block back into interrupt mode.

Pins 7 to 15 double as interrupt lines 15 down to 7. When such a pin is an output, the matching interrupt line reads back the driven value. The timer counter and the priority encoder live outside this block. It only hands them interval bit writes and the enable mask.

Top module: `sbr_regif`

## Requirements
- R1: Writing location 0 stores the data bit as the mode (1 = clock mode, 0 = interrupt mode), visible from the next cycle. Reading location 0 returns the mode.
- R2: In interrupt mode, a write to location n (1..15) sets or clears enable bit n from the next cycle. No other enable bit changes, and no interval write is issued.
- R3: In clock mode, a write to location n (1..14) raises `ivl_wr` in the same cycle, with `ivl_idx` = n-1 and `ivl_val` equal to the data bit. The enable mask does not change.
- R4: In interrupt mode, a read of location n (1..15) returns `int_lvl[n]`. The exception is n >= 7 when pin 22-n is an output: the read then returns that pin's driven value.
- R5: In clock mode, a read of location n (1..14) returns `cnt_latched[n-1]`, and a read of location 15 returns `irq_req_n`.
- R6: In clock mode, writing 0 to location 15 clears every pin direction and every enable bit from the next cycle, and leaves the pin output values unchanged. Writing 1 there changes nothing.
- R7: A write to location 16+n sets `pin_out[n]` to the data bit and sets `pin_dir[n]` to 1 (output) from the next cycle.
- R8: Any read or write strobe at a location of 16 or above clears the mode to interrupt mode from the next cycle.
- R9: A read of location 16+n returns `pin_out[n]` when the pin is an output, and `pin_lvl[n]` otherwise.
- R10: While `rst_n` is low, the mode, the enables, the pin directions and the pin output values are all 0, and `ivl_wr` is 0 whenever no strobe is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel_addr | input | 5 | Bit location select |
| wr_stb | input | 1 | Write strobe for the selected bit |
| wr_bit | input | 1 | Data bit to write |
| rd_stb | input | 1 | Read strobe (only its side effect on the mode is registered) |
| rd_bit | output | 1 | Read data for the selected location, combinational |
| pin_lvl | input | 16 | External level of each pin |
| int_lvl | input | 15 | Interrupt line levels, lines 1..15 |
| cnt_latched | input | 14 | Latched timer count from the timer core |
| irq_req_n | input | 1 | Active-low interrupt request level from the encoder |
| mode_clk | output | 1 | Current mode, 1 = clock mode |
| en_mask | output | 15 | Interrupt enable bits, lines 1..15 |
| ivl_wr | output | 1 | Interval bit write pulse to the timer core |
| ivl_idx | output | 4 | Index of the interval bit being written |
| ivl_val | output | 1 | Value of the interval bit being written |
| pin_out | output | 16 | Driven value of each pin |
| pin_dir | output | 16 | Pin direction, 1 = output |

## Verification
Directed sequences cover four cases: mode entry and exit through location 0, interval writes against enable writes at the same location in the two modes, a soft reset with a data bit of 1 and then of 0, and a read of every shared line before and after its mirrored pin becomes an output. These separate the two meanings of locations 1 to 15. They also show whether the reversed pin-to-line map is applied. A long run of mixed strobes and addresses, with randomized pin, line, count and request inputs, follows. It exposes mode leaks caused by reads in the upper half and direction bits that stick after a soft reset.

// File: rtl/sbr_pkg.sv
package sbr_pkg;
   // Regions of the single-bit location space.
   typedef enum logic [1:0] {
      AR_MODE  = 2'd0,   // location 0
      AR_FIELD = 2'd1,   // locations 1 .. PIN_N-2
      AR_TOP   = 2'd2,   // location PIN_N-1
      AR_PIN   = 2'd3    // locations PIN_N .. 2*PIN_N-1
   } area_e;
endpackage

// File: rtl/sbr_mode_reg.sv
module sbr_mode_reg (
   input  logic clk,
   input  logic rst_n,
   input  logic load,
   input  logic load_val,
   input  logic leave,
   output logic mode_q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      mode_q <= 1'b0;
      else if (load)   mode_q <= load_val;
      else if (leave)  mode_q <= 1'b0;
   end
endmodule

// File: rtl/sbr_enable_bank.sv
module sbr_enable_bank #(
   parameter int PIN_N = 16,
   localparam int IDX_W = $clog2(PIN_N)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr,
   input  logic [IDX_W-1:0] idx,
   input  logic             val,
   input  logic             clr_all,
   output logic [PIN_N-1:1] en_q
);
   for (genvar i = 1; i < PIN_N; i++) begin : g_en
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                             en_q[i] <= 1'b0;
         else if (clr_all)                       en_q[i] <= 1'b0;
         else if (wr && (idx == IDX_W'(i)))      en_q[i] <= val;
      end
   end
endmodule

// File: rtl/sbr_pin_bank.sv
module sbr_pin_bank #(
   parameter int PIN_N = 16,
   localparam int IDX_W = $clog2(PIN_N)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr,
   input  logic [IDX_W-1:0] idx,
   input  logic             val,
   input  logic             dir_clr,
   output logic [PIN_N-1:0] out_q,
   output logic [PIN_N-1:0] dir_q
);
   for (genvar n = 0; n < PIN_N; n++) begin : g_pin
      logic hit;
      assign hit = wr && (idx == IDX_W'(n));
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)       dir_q[n] <= 1'b0;
         else if (dir_clr) dir_q[n] <= 1'b0;
         else if (hit)     dir_q[n] <= 1'b1;
      end
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)   out_q[n] <= 1'b0;
         else if (hit) out_q[n] <= val;
      end
   end
endmodule

// File: rtl/sbr_read_mux.sv
module sbr_read_mux
   import sbr_pkg::*;
#(
   parameter int PIN_N    = 16,
   parameter int SHARE_LO = 7,
   localparam int IDX_W   = $clog2(PIN_N),
   localparam int CNT_W   = PIN_N - 2,
   localparam int MIR_SUM = PIN_N - 1 + SHARE_LO
) (
   input  logic             mode,
   input  area_e            area,
   input  logic [IDX_W-1:0] lo,
   input  logic [PIN_N-1:0] pin_lvl,
   input  logic [PIN_N-1:1] int_lvl,
   input  logic [PIN_N-1:0] pin_out,
   input  logic [PIN_N-1:0] pin_dir,
   input  logic [CNT_W-1:0] cnt_latched,
   input  logic             irq_req_n,
   output logic             rd_bit
);
   logic [PIN_N-1:0] line_rd;
   logic [PIN_N-1:0] pin_rd;
   logic [IDX_W-1:0] fidx;

   assign line_rd[0] = 1'b0;
   for (genvar i = 1; i < PIN_N; i++) begin : g_line
      if (i >= SHARE_LO) begin : g_shared
         // shared line i is pin MIR_SUM-i; an output pin reads back its drive
         assign line_rd[i] = pin_dir[MIR_SUM-i] ? pin_out[MIR_SUM-i] : int_lvl[i];
      end else begin : g_plain
         assign line_rd[i] = int_lvl[i];
      end
   end

   for (genvar n = 0; n < PIN_N; n++) begin : g_prd
      assign pin_rd[n] = pin_dir[n] ? pin_out[n] : pin_lvl[n];
   end

   assign fidx = lo - IDX_W'(1);

   always_comb begin
      unique case (area)
         AR_MODE:  rd_bit = mode;
         AR_FIELD: rd_bit = mode ? cnt_latched[fidx] : line_rd[lo];
         AR_TOP:   rd_bit = mode ? irq_req_n : line_rd[lo];
         default:  rd_bit = pin_rd[lo];
      endcase
   end
endmodule

// File: rtl/sbr_regif.sv
module sbr_regif
   import sbr_pkg::*;
#(
   parameter int PIN_N    = 16,
   parameter int SHARE_LO = 7,
   localparam int IDX_W   = $clog2(PIN_N),
   localparam int ADDR_W  = IDX_W + 1,
   localparam int CNT_W   = PIN_N - 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [ADDR_W-1:0] sel_addr,
   input  logic             wr_stb,
   input  logic             wr_bit,
   input  logic             rd_stb,
   output logic             rd_bit,
   input  logic [PIN_N-1:0] pin_lvl,
   input  logic [PIN_N-1:1] int_lvl,
   input  logic [CNT_W-1:0] cnt_latched,
   input  logic             irq_req_n,
   output logic             mode_clk,
   output logic [PIN_N-1:1] en_mask,
   output logic             ivl_wr,
   output logic [IDX_W-1:0] ivl_idx,
   output logic             ivl_val,
   output logic [PIN_N-1:0] pin_out,
   output logic [PIN_N-1:0] pin_dir
);
   if ((PIN_N & (PIN_N - 1)) != 0 || PIN_N < 4) begin : g_bad_pins
      $error("sbr_regif: PIN_N must be a power of two, at least 4");
   end
   if (SHARE_LO < 1 || SHARE_LO > PIN_N - 1) begin : g_bad_share
      $error("sbr_regif: SHARE_LO must lie in 1..PIN_N-1");
   end

   logic             in_pin;
   logic [IDX_W-1:0] lo;
   area_e            area;

   assign in_pin = sel_addr[ADDR_W-1];
   assign lo     = sel_addr[IDX_W-1:0];

   always_comb begin
      if (in_pin)                          area = AR_PIN;
      else if (lo == '0)                   area = AR_MODE;
      else if (lo == IDX_W'(PIN_N - 1))    area = AR_TOP;
      else                                 area = AR_FIELD;
   end

   logic mode_ld, leave, en_wr, soft_rst, pin_wr;

   assign mode_ld  = wr_stb && (area == AR_MODE);
   assign leave    = (wr_stb || rd_stb) && (area == AR_PIN);
   assign en_wr    = wr_stb && !mode_clk && (area == AR_FIELD || area == AR_TOP);
   assign soft_rst = wr_stb && mode_clk && (area == AR_TOP) && !wr_bit;
   assign pin_wr   = wr_stb && (area == AR_PIN);

   assign ivl_wr   = wr_stb && mode_clk && (area == AR_FIELD);
   assign ivl_idx  = lo - IDX_W'(1);
   assign ivl_val  = wr_bit;

   sbr_mode_reg i_mode (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (mode_ld),
      .load_val (wr_bit),
      .leave    (leave),
      .mode_q   (mode_clk)
   );

   sbr_enable_bank #(.PIN_N(PIN_N)) i_en (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr      (en_wr),
      .idx     (lo),
      .val     (wr_bit),
      .clr_all (soft_rst),
      .en_q    (en_mask)
   );

   sbr_pin_bank #(.PIN_N(PIN_N)) i_pins (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr      (pin_wr),
      .idx     (lo),
      .val     (wr_bit),
      .dir_clr (soft_rst),
      .out_q   (pin_out),
      .dir_q   (pin_dir)
   );

   sbr_read_mux #(.PIN_N(PIN_N), .SHARE_LO(SHARE_LO)) i_rd (
      .mode        (mode_clk),
      .area        (area),
      .lo          (lo),
      .pin_lvl     (pin_lvl),
      .int_lvl     (int_lvl),
      .pin_out     (pin_out),
      .pin_dir     (pin_dir),
      .cnt_latched (cnt_latched),
      .irq_req_n   (irq_req_n),
      .rd_bit      (rd_bit)
   );
endmodule

// File: rtl/sbr_regif_chk.sv
module sbr_regif_chk #(
   parameter int PIN_N    = 16,
   localparam int IDX_W   = $clog2(PIN_N),
   localparam int ADDR_W  = IDX_W + 1
) (
   input logic              clk,
   input logic              rst_n,
   input logic [ADDR_W-1:0] sel_addr,
   input logic              wr_stb,
   input logic              wr_bit,
   input logic              rd_stb,
   input logic              mode_clk,
   input logic [PIN_N-1:1]  en_mask,
   input logic [PIN_N-1:0]  pin_out,
   input logic [PIN_N-1:0]  pin_dir
);
   logic upper, low_any, low_field, low_top;
   assign upper     = sel_addr[ADDR_W-1];
   assign low_any   = !upper && (sel_addr[IDX_W-1:0] != '0);
   assign low_top   = !upper && (sel_addr[IDX_W-1:0] == IDX_W'(PIN_N - 1));
   assign low_field = low_any && !low_top;

   assert_mode_load_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_stb && sel_addr == '0) |=> (mode_clk == $past(wr_bit)));

   assert_enable_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_stb && !mode_clk && low_any)
      |=> (en_mask[$past(sel_addr[IDX_W-1:0])] == $past(wr_bit)));

   assert_enable_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_stb && mode_clk && low_field) |=> $stable(en_mask));

   assert_soft_reset_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_stb && mode_clk && low_top && !wr_bit)
      |=> (pin_dir == '0 && en_mask == '0 && $stable(pin_out)));

   assert_pin_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_stb && upper)
      |=> (pin_dir[$past(sel_addr[IDX_W-1:0])]
           && pin_out[$past(sel_addr[IDX_W-1:0])] == $past(wr_bit)));

   assert_mode_leave_R8: assert property (@(posedge clk) disable iff (!rst_n)
      ((wr_stb || rd_stb) && upper) |=> !mode_clk);
endmodule

bind sbr_regif sbr_regif_chk #(.PIN_N(PIN_N)) i_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .sel_addr (sel_addr),
   .wr_stb   (wr_stb),
   .wr_bit   (wr_bit),
   .rd_stb   (rd_stb),
   .mode_clk (mode_clk),
   .en_mask  (en_mask),
   .pin_out  (pin_out),
   .pin_dir  (pin_dir)
);

// File: tb/test_sbr_regif.sv
`timescale 1ns/1ps
module test_sbr_regif;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [4:0]  sel_addr = '0;
   logic        wr_stb = 1'b0, wr_bit = 1'b0, rd_stb = 1'b0;
   logic        rd_bit;
   logic [15:0] pin_lvl = '0;
   logic [15:1] int_lvl = '0;
   logic [13:0] cnt_latched = '0;
   logic        irq_req_n = 1'b1;
   logic        mode_clk, ivl_wr, ivl_val;
   logic [15:1] en_mask;
   logic [3:0]  ivl_idx;
   logic [15:0] pin_out, pin_dir;

   int vectors = 0;
   int errors  = 0;

   // reference state
   bit        m_mode;
   bit [15:0] m_en, m_dir, m_out;

   always #2.5 clk = ~clk;

   sbr_regif i_sbr_regif (
      .clk(clk), .rst_n(rst_n), .sel_addr(sel_addr), .wr_stb(wr_stb),
      .wr_bit(wr_bit), .rd_stb(rd_stb), .rd_bit(rd_bit), .pin_lvl(pin_lvl),
      .int_lvl(int_lvl), .cnt_latched(cnt_latched), .irq_req_n(irq_req_n),
      .mode_clk(mode_clk), .en_mask(en_mask), .ivl_wr(ivl_wr),
      .ivl_idx(ivl_idx), .ivl_val(ivl_val), .pin_out(pin_out), .pin_dir(pin_dir)
   );

   task automatic chk(input string tag, input string what,
                      input logic [15:0] act, input logic [15:0] exp);
      vectors++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: actual %h expected %h at %0t", tag, what, act, exp, $time);
      end
   endtask

   function automatic bit exp_read(int a);
      int n;
      if (a >= 16) begin
         n = a - 16;
         return m_dir[n] ? m_out[n] : pin_lvl[n];                 // R9
      end
      if (a == 0) return m_mode;                                  // R1
      if (m_mode) return (a == 15) ? irq_req_n : cnt_latched[a-1]; // R5
      if (a >= 7 && m_dir[22-a]) return m_out[22-a];              // R4 shared
      return int_lvl[a];                                          // R4
   endfunction

   function automatic string rd_tag(int a);
      if (a >= 16) return "R9";
      if (a == 0)  return "R1";
      return m_mode ? "R5" : "R4";
   endfunction

   // compare all outputs against the model, then advance the model
   task automatic compare_and_advance();
      int a = int'(sel_addr);
      bit ex_ivl = wr_stb && m_mode && a >= 1 && a <= 14;
      chk("R1", "mode_clk", {15'd0, mode_clk}, {15'd0, m_mode});
      chk("R2", "en_mask", {en_mask, 1'b0}, m_en);
      chk("R7", "pin_dir", pin_dir, m_dir);
      chk("R7", "pin_out", pin_out, m_out);
      chk("R3", "ivl_wr", {15'd0, ivl_wr}, {15'd0, ex_ivl});
      if (ex_ivl) begin
         chk("R3", "ivl_idx", {12'd0, ivl_idx}, 16'(a - 1));
         chk("R3", "ivl_val", {15'd0, ivl_val}, {15'd0, wr_bit});
      end
      chk(rd_tag(a), "rd_bit", {15'd0, rd_bit}, {15'd0, exp_read(a)});
      if (!rst_n) begin
         m_mode = 0; m_en = '0; m_dir = '0; m_out = '0;
         return;
      end
      if (wr_stb) begin
         if (a == 0) m_mode = wr_bit;
         else if (a >= 16) begin
            m_dir[a-16] = 1'b1;
            m_out[a-16] = wr_bit;
            m_mode = 0;
         end else if (!m_mode) m_en[a] = wr_bit;
         else if (a == 15 && !wr_bit) begin     // R6
            m_dir = '0; m_en = '0;
         end
      end
      if (rd_stb && a >= 16) m_mode = 0;        // R8
   endtask

   task automatic step(input bit w, input bit r, input int a, input bit d);
      @(negedge clk);
      wr_stb = w; rd_stb = r; sel_addr = 5'(a); wr_bit = d;
      #1;
      compare_and_advance();
   endtask

   task automatic shuffle_inputs();
      pin_lvl = 16'($urandom);
      int_lvl = 15'($urandom);
      cnt_latched = 14'($urandom);
      irq_req_n = 1'($urandom);
   endtask

   initial begin
      #(200000 * 5);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
   end

   initial begin
      m_mode = 0; m_en = '0; m_dir = '0; m_out = '0;
      void'($urandom(13));
      // R10: reset state, with strobes active during reset
      step(1, 0, 17, 1);
      step(1, 0, 0, 1);
      step(0, 0, 0, 0);
      @(negedge clk); rst_n = 1'b1;

      // R1: enter clock mode and read location 0
      step(1, 0, 0, 1);
      step(0, 1, 0, 0);
      // R3: interval writes leave enables alone; R5: count and request reads
      cnt_latched = 14'h2A5C; irq_req_n = 1'b0;
      for (int i = 1; i <= 14; i++) step(1, 0, i, i[0]);
      for (int i = 1; i <= 15; i++) step(0, 1, i, 0);
      irq_req_n = 1'b1;
      step(0, 1, 15, 0);
      // R8: a read in the upper half leaves clock mode
      step(0, 1, 20, 0);
      step(0, 0, 0, 0);
      // R2: enables in interrupt mode, including location 15
      for (int i = 1; i <= 15; i++) step(1, 0, i, 1);
      step(1, 0, 9, 0);
      // R4: shared lines before any pin is an output
      int_lvl = 15'h5A5A;
      for (int i = 1; i <= 15; i++) step(0, 1, i, 0);
      // R7/R9: drive pins 7..15 opposite to the line levels, and pin 2
      pin_lvl = 16'h0F0F;
      for (int n = 7; n <= 15; n++) step(1, 0, 16 + n, ~int_lvl[22-n]);
      step(1, 0, 18, 1);
      for (int n = 0; n < 16; n++) step(0, 1, 16 + n, 0);
      // R4: shared lines now read back the mirrored pin drive
      for (int i = 1; i <= 15; i++) step(0, 1, i, 0);
      // R6: soft reset with a 1 has no effect, with a 0 clears dir and enables
      step(1, 0, 0, 1);
      step(1, 0, 15, 1);
      step(0, 0, 15, 0);
      step(1, 0, 15, 0);
      step(0, 1, 15, 0);
      // R8: a write in the upper half also leaves clock mode
      step(1, 0, 31, 1);
      step(0, 0, 0, 0);

      // mixed traffic
      for (int k = 0; k < 4000; k++) begin
         int sel = int'($urandom_range(0, 9));
         int a;
         bit w, r;
         shuffle_inputs();
         a = (sel < 2) ? 0 : (sel < 4) ? 15 : int'($urandom_range(0, 31));
         w = 1'($urandom);
         r = !w && 1'($urandom);
         step(w, r, a, 1'($urandom));
      end

      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
   end
endmodule